// File: doc/BRIEF.md
# Condition Flags and Branch Resolver

This block keeps the four status bits of a 64-bit core (negative, zero, carry, overflow) and resolves branches. Each cycle it receives the two operands of the current arithmetic or logic operation together with an operation select and a flag-setting strobe. When the strobe is high and the operation is an add, a subtract or an AND, the block computes fresh status bits and stores them at the clock edge. Any other operation, and any cycle without the strobe, leaves the stored bits untouched.

In the same cycle the block decides whether a branch is taken. A branch is either unconditional, a test of the stored status bits against one of ten condition codes, or a test of a register value for zero or nonzero. The register tests ignore the status bits entirely. For a taken branch the block adds a sign-extended word offset, scaled by four, to the address of the branch instruction itself. Branch decisions always use the status bits held before the current edge, so a flag-setting operation and a branch in the same cycle see the older flags.

Top module: `flag_branch_unit`

## Requirements
- R1: `flags_q` holds the status bits as {N, Z, C, V} in bits 3 down to 0, and reads 4'b0000 on the cycle after a clock edge with `rst_n` low.
- R2: On a flag update, N equals bit 63 of the operation result, and Z is 1 exactly when all 64 result bits are 0.
- R3: For an add (`op_sel` = 0), the result is a + b, C is the carry out of bit 63, and V is 1 when the true signed sum does not fit in 64 bits.
- R4: For a subtract (`op_sel` = 1), the result is a - b, C is the carry out of a + ~b + 1 (1 when a >= b unsigned), and V is 1 when the true signed difference does not fit in 64 bits.
- R5: For an AND (`op_sel` = 2), the result is a & b and both C and V are written as 0.
- R6: Stored flags change only at a clock edge where `set_flags` is 1 and `op_sel` is 0, 1 or 2; `op_sel` = 3 or `set_flags` = 0 leaves `flags_q` unchanged.
- R7: With `br_kind` = 2, the branch is taken according to `cond_code` on the stored flags: 0 Z, 1 not Z, 2 C, 3 not C, 4 C and not Z, 5 not C or Z, 6 N equal V, 7 N differs from V, 8 not Z and N equal V, 9 Z or N differs from V; codes 10 to 15 are never taken.
- R8: After a flag-setting subtract of all-ones minus 1, code 7 (signed less) is taken, code 3 (unsigned lower) is not taken and code 4 (unsigned higher) is taken.
- R9: With `br_kind` = 3 the branch is taken when `test_val` is 0, with `br_kind` = 4 when `test_val` is nonzero, independent of the stored flags, and neither kind changes them.
- R10: With `br_kind` = 1 the branch is always taken and uses all 26 bits of `br_off` as a signed offset.
- R11: A taken branch gives `br_target` = `pc` + 4 × offset, where the offset is `br_off` sign-extended from bit 25 for `br_kind` = 1 and from bit 18 (bits 25:19 ignored) for kinds 2, 3 and 4.
- R12: When no branch is taken (including `br_kind` = 0 and 5 to 7), `br_taken` is 0 and `br_target` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 other |
| set_flags | input | 1 | Current operation is a flag-setting variant |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand (register or immediate) |
| br_kind | input | 3 | 0 none, 1 unconditional, 2 conditional, 3 zero test, 4 nonzero test |
| cond_code | input | 4 | Condition selector for conditional branches |
| test_val | input | 64 | Register tested by zero/nonzero branches |
| pc | input | 64 | Address of the branch instruction |
| br_off | input | 26 | Word offset, 26 or 19 significant bits |
| flags_q | output | 4 | Stored {N, Z, C, V} |
| br_taken | output | 1 | Branch taken this cycle |
| br_target | output | 64 | Branch destination, 0 when not taken |

## Verification
Operands are drawn from a pool weighted toward 0, 1, all-ones and the two signed extremes, mixed with random values, so adds and subtracts hit carry-without-overflow, overflow-without-carry, both and neither, and the zero and negative results separate N from Z. Flag-setting and non-setting cycles, including the "other" operation with the strobe high, are interleaved so a stale or wrongly updated flag shows up in a later conditional branch. Every condition code is tried against these varied flag states, which tells signed from unsigned comparisons, and a directed all-ones versus one subtract pins that difference. Register tests are driven with zero and nonzero values under random flags, and offsets with either sign bit set expose wrong extension width or scaling.

// File: rtl/fbr_pkg.sv
// Shared types for the flag and branch resolver.
// Assumes a single-issue core that presents one operation and one branch per cycle.
package fbr_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_AND  = 2'd2,
        OP_PASS = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        BK_NONE   = 3'd0,
        BK_JUMP   = 3'd1,
        BK_COND   = 3'd2,
        BK_ZERO   = 3'd3,
        BK_NZERO  = 3'd4
    } br_kind_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,
        CC_NE = 4'd1,
        CC_HS = 4'd2,
        CC_LO = 4'd3,
        CC_HI = 4'd4,
        CC_LS = 4'd5,
        CC_GE = 4'd6,
        CC_LT = 4'd7,
        CC_GT = 4'd8,
        CC_LE = 4'd9
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/fbr_flag_gen.sv
// Computes candidate status bits for an add, subtract or AND of two operands.
// Assumes subtract is done as a + ~b + 1 so that carry means "no borrow".
// Purely combinational; the caller decides whether to store the result.
module fbr_flag_gen
    import fbr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  alu_op_e           op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output flags_t            nxt,
    output logic              can_set
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   sum_w;
    logic [XLEN-1:0] res;

    // Form the adder input, run the adder, and derive the four bits.
    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, (op == OP_SUB)};
        if (op == OP_AND) begin
            res   = a & b;
            nxt.c = 1'b0;
            nxt.v = 1'b0;
        end else begin
            res   = sum_w[MSB:0];
            nxt.c = sum_w[XLEN];
            nxt.v = (a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB]);
        end
        nxt.n = res[MSB];
        nxt.z = (res == '0);
    end

    // Only the three arithmetic/logic kinds are allowed to write flags.
    assign can_set = (op != OP_PASS);

    // R2: a zero result can never look negative.
    always_comb begin
        a_r2_zero_not_negative: assert (!(nxt.z && nxt.n));
    end

endmodule

// File: rtl/fbr_cond_eval.sv
// Evaluates a condition code against stored status bits.
// Assumes codes above the last defined one mean "never".
module fbr_cond_eval
    import fbr_pkg::*;
(
    input  flags_t     f,
    input  logic [3:0] code,
    output logic       hit
);
    logic lt_s, le_s, hi_u;

    // Build the shared signed/unsigned terms, then select by code.
    always_comb begin
        lt_s = f.n ^ f.v;
        le_s = f.z | lt_s;
        hi_u = f.c & ~f.z;
        unique case (code)
            CC_EQ:   hit = f.z;
            CC_NE:   hit = ~f.z;
            CC_HS:   hit = f.c;
            CC_LO:   hit = ~f.c;
            CC_HI:   hit = hi_u;
            CC_LS:   hit = ~hi_u;
            CC_GE:   hit = ~lt_s;
            CC_LT:   hit = lt_s;
            CC_GT:   hit = ~le_s;
            CC_LE:   hit = le_s;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fbr_target_gen.sv
// Adds a sign-extended, word-scaled offset to the branch's own address.
// Assumes instructions are 32 bits wide, hence a shift of two.
module fbr_target_gen #(
    parameter int XLEN     = 64,
    parameter int LONG_W   = 26,
    parameter int SHORT_W  = 19,
    parameter int WORD_SH  = 2
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [LONG_W-1:0] off,
    input  logic              use_long,
    output logic [XLEN-1:0]   tgt
);
    logic [XLEN-1:0] ext;

    // Pick the offset width, extend its sign, scale and add.
    always_comb begin
        if (use_long)
            ext = {{(XLEN-LONG_W){off[LONG_W-1]}}, off};
        else
            ext = {{(XLEN-SHORT_W){off[SHORT_W-1]}}, off[SHORT_W-1:0]};
        tgt = pc + (ext << WORD_SH);
    end

endmodule

// File: rtl/flag_branch_unit.sv
// Status-bit register plus branch decision and target generation.
// Assumes branch decisions use the flags stored before the current edge;
// a flag-setting operation in the same cycle affects only later branches.
module flag_branch_unit
    import fbr_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int LONG_W  = 26,
    parameter int SHORT_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_sel,
    input  logic              set_flags,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [2:0]        br_kind,
    input  logic [3:0]        cond_code,
    input  logic [XLEN-1:0]   test_val,
    input  logic [XLEN-1:0]   pc,
    input  logic [LONG_W-1:0] br_off,
    output logic [3:0]        flags_q,
    output logic              br_taken,
    output logic [XLEN-1:0]   br_target
);
    flags_t          flags_r;
    flags_t          flags_nxt;
    logic            op_can_set;
    logic            cond_hit;
    logic [XLEN-1:0] raw_target;
    br_kind_e        kind;

    assign kind = br_kind_e'(br_kind);

    fbr_flag_gen #(.XLEN(XLEN)) u_flag_gen (
        .op      (alu_op_e'(op_sel)),
        .a       (opnd_a),
        .b       (opnd_b),
        .nxt     (flags_nxt),
        .can_set (op_can_set)
    );

    fbr_cond_eval u_cond_eval (
        .f    (flags_r),
        .code (cond_code),
        .hit  (cond_hit)
    );

    fbr_target_gen #(
        .XLEN(XLEN), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .WORD_SH(2)
    ) u_target_gen (
        .pc       (pc),
        .off      (br_off),
        .use_long (kind == BK_JUMP),
        .tgt      (raw_target)
    );

    // Store new status bits only for flag-setting add/subtract/AND.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_r <= '0;
        else if (set_flags && op_can_set)
            flags_r <= flags_nxt;
    end

    assign flags_q = flags_r;

    // Decide taken by branch kind; zero/nonzero tests never look at flags.
    always_comb begin
        unique case (kind)
            BK_JUMP:  br_taken = 1'b1;
            BK_COND:  br_taken = cond_hit;
            BK_ZERO:  br_taken = (test_val == '0);
            BK_NZERO: br_taken = (test_val != '0);
            default:  br_taken = 1'b0;
        endcase
    end

    // Present the destination only for a taken branch.
    assign br_target = br_taken ? raw_target : '0;

    // R1: reset clears the stored bits.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 4'b0000));

    // R6: no flag-setting add/sub/AND means the stored bits hold.
    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags || op_sel == 2'd3) |=> $stable(flags_q));

    // R9: a zero register under a zero test is always taken.
    a_r9_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd3 && test_val == '0) |-> br_taken);

    // R10: the unconditional kind is always taken.
    a_r10_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 3'd1) |-> br_taken);

    // R12: a branch that is not taken leaves the target at zero.
    a_r12_idle_target: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> (br_target == '0));

endmodule

// File: tb/flag_branch_unit_bench.sv
// Reference-model bench: behavioural model of the flags and branch result,
// compared against the design every cycle.
module flag_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = '0;
    logic        set_flags = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [2:0]  br_kind = '0;
    logic [3:0]  cond_code = '0;
    logic [63:0] test_val = '0, pc = '0;
    logic [25:0] br_off = '0;
    logic [3:0]  flags_q;
    logic        br_taken;
    logic [63:0] br_target;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_flags = 4'b0;   // model {N,Z,C,V}

    flag_branch_unit u_flag_branch_unit (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .set_flags(set_flags),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .br_kind(br_kind),
        .cond_code(cond_code), .test_val(test_val), .pc(pc), .br_off(br_off),
        .flags_q(flags_q), .br_taken(br_taken), .br_target(br_target)
    );

    always #5 clk = ~clk;

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model_cond(input logic [3:0] f, input logic [3:0] cc);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0: return z;
            4'd1: return !z;
            4'd2: return c;
            4'd3: return !c;
            4'd4: return c && !z;
            4'd5: return !c || z;
            4'd6: return n == v;
            4'd7: return n != v;
            4'd8: return !z && (n == v);
            4'd9: return z || (n != v);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] model_flags(input logic [1:0] op,
                                              input logic [63:0] a, input logic [63:0] b);
        logic signed [64:0] wide;
        logic [63:0] r;
        logic c, v;
        if (op == 2'd0) begin
            wide = $signed({a[63], a}) + $signed({b[63], b});
            r = a + b;
            c = (r < a);
            v = (wide[64] != wide[63]);
        end else if (op == 2'd1) begin
            wide = $signed({a[63], a}) - $signed({b[63], b});
            r = a - b;
            c = (a >= b);
            v = (wide[64] != wide[63]);
        end else begin
            r = a & b;
            c = 1'b0;
            v = 1'b0;
        end
        return {r[63], (r == 64'd0), c, v};
    endfunction

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 7))
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    // One cycle: inputs already driven; check branch outputs, clock, check flags.
    task automatic step();
        logic exp_t;
        logic [63:0] exp_tgt;
        longint ofs;
        #2;
        case (br_kind)
            3'd1: exp_t = 1'b1;
            3'd2: exp_t = model_cond(m_flags, cond_code);
            3'd3: exp_t = (test_val == 64'd0);
            3'd4: exp_t = (test_val != 64'd0);
            default: exp_t = 1'b0;
        endcase
        if (br_kind == 3'd1) begin
            ofs = longint'(br_off);
            if (br_off[25]) ofs = ofs - 64'sd67108864;
        end else begin
            ofs = longint'(br_off[18:0]);
            if (br_off[18]) ofs = ofs - 64'sd524288;
        end
        exp_tgt = exp_t ? (pc + 64'(ofs * 4)) : 64'd0;
        // R7 R9 R10 R12: decision; R11 R12: target
        check64("R7/R9/R10/R12 taken", 64'(br_taken), 64'(exp_t));
        check64("R11/R12 target", br_target, exp_tgt);
        @(posedge clk);
        if (set_flags && op_sel != 2'd3)
            m_flags = model_flags(op_sel, opnd_a, opnd_b);
        @(negedge clk);
        // R2 R3 R4 R5 R6: stored flags after the edge
        check64("R2-R6 flags", 64'(flags_q), 64'(m_flags));
    endtask

    task automatic drive(input logic [1:0] op, input logic sf, input logic [63:0] a,
                         input logic [63:0] b, input logic [2:0] bk, input logic [3:0] cc,
                         input logic [63:0] tv, input logic [63:0] p, input logic [25:0] off);
        op_sel = op; set_flags = sf; opnd_a = a; opnd_b = b; br_kind = bk;
        cond_code = cc; test_val = tv; pc = p; br_off = off;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        drive(2'd0, 1'b1, '1, 64'd1, 3'd0, 4'd0, 64'd0, 64'd0, 26'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check64("R1 reset flags", 64'(flags_q), 64'd0);
        rst_n = 1'b1;

        // R8: all-ones minus one, then signed/unsigned conditions
        drive(2'd1, 1'b1, '1, 64'd1, 3'd0, 4'd0, 64'd0, 64'h1000, 26'd0);
        step();
        drive(2'd3, 1'b1, 64'd0, 64'd0, 3'd2, 4'd7, 64'd0, 64'h1000, 26'd4);
        step();
        check64("R8 signed less taken", 64'(br_taken), 64'd1);
        drive(2'd3, 1'b0, 64'd0, 64'd0, 3'd2, 4'd3, 64'd0, 64'h1000, 26'd4);
        step();
        drive(2'd3, 1'b0, 64'd0, 64'd0, 3'd2, 4'd4, 64'd0, 64'h1000, 26'd4);
        step();

        // R9: zero tests ignore flags; R10/R11 negative offsets
        drive(2'd3, 1'b0, 64'd0, 64'd0, 3'd3, 4'd0, 64'd0, 64'h2000, 26'h3FFFFFF);
        step();
        drive(2'd3, 1'b0, 64'd0, 64'd0, 3'd4, 4'd0, 64'd5, 64'h2000, 26'h0040000);
        step();
        drive(2'd3, 1'b0, 64'd0, 64'd0, 3'd1, 4'd0, 64'd0, 64'h2000, 26'h2000000);
        step();

        // Mixed random traffic across all kinds, codes and operations
        for (int i = 0; i < 4000; i++) begin
            drive(2'($urandom_range(0, 3)), 1'($urandom_range(0, 2) != 0),
                  pick(), pick(), 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                  ($urandom_range(0, 1) != 0) ? 64'd0 : pick(),
                  {$urandom, $urandom}, 26'($urandom));
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule